// File: doc/BRIEF.md
# ECC Syndrome to Memory Module Locator

This block turns a corrected-or-detected ECC event into a hardware location. A request carries a syndrome code, the quadword select taken from the failing line address, the low bit of the claiming bank's number and a flag saying whether any bank claimed the address at all. For a single-bit syndrome the block names one of eight memory modules, given as a one-hot mask, and the connector pin number. For the multi-bit code it sets all four module bits of the bank's group. When the code is illegal, no bank claimed the address, or the computed line position falls outside the line, it raises an unknown flag.

Each result is found by reordering the syndrome into bus bit order and placing it within the 576-bit line. The block then reads two tables. One is a packed module-select map, four 2-bit entries per byte. The other is a 576-entry pin table. Two sets of these tables are held, loaded byte by byte through a write port. A layout flag sent with each request picks the set.

The lookup is a two-register pipeline and accepts a request on every cycle. The first register holds a classification state: NONE, UNKNOWN, MULTI or SINGLE. On every clock edge this state is loaded from the request of that cycle, going to NONE when there is no request, so there is no hold or wait state. The second register holds the outputs.

Top module: `syn_dimm_locator`

## Requirements
- R1: After reset, and in every cycle that carries no result, res_valid, res_unknown, res_multi, mod_mask and pin_num are all zero.
- R2: A request sampled at clock edge t gives res_valid high for exactly the cycle after edge t+1. Requests on consecutive cycles give results on consecutive cycles, in order.
- R3: A syndrome (9-bit two's complement) below -1 or above 144, or any request with bank_hit low, gives res_unknown=1 with mod_mask=0, pin_num=0 and res_multi=0.
- R4: A single-bit code c is remapped as follows. c+16 for c in 0..127, c-137 for c in 128..143, and c-143 for c=144.
- R5: Line position = (3 - qword_sel)*144 + remapped code, where qword_sel is line address bits [5:4]. A negative position gives res_unknown=1.
- R6: The reversed position is 575 - position. Module-map byte number (reversed >> 2) is read, and its bit 2*(3 - (reversed & 3)) is the map bit. mod_mask is one-hot at bit 4*bank_group + map bit.
- R7: For a single-bit result, pin_num is the pin-table entry at the line position (not reversed).
- R8: layout_sym=1 selects table set 0 and layout_sym=0 selects set 1. The flag is sampled with the request.
- R9: Syndrome -1 with bank_hit high gives res_multi=1, res_unknown=0 and pin_num=0. mod_mask is 8'h0F for bank_group 0 and 8'hF0 for bank_group 1.
- R10: A cycle with tbl_we high writes tbl_wdata into set tbl_set at entry tbl_addr of the module map (tbl_kind=0, entries 0..143) or the pin table (tbl_kind=1, entries 0..575). Requests sampled at later edges see the written value, and the other set is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Lookup request strobe |
| syndrome | input | SYN_W | Signed syndrome code; -1 means multi-bit |
| qword_sel | input | 2 | Failing line address bits [5:4] |
| bank_group | input | 1 | Bit 0 of the claiming bank number |
| bank_hit | input | 1 | A bank claimed the address |
| layout_sym | input | 1 | 1 selects table set 0, 0 selects set 1 |
| tbl_we | input | 1 | Table write enable |
| tbl_set | input | 1 | Table set written |
| tbl_kind | input | 1 | 0 module map, 1 pin table |
| tbl_addr | input | 10 | Table entry written |
| tbl_wdata | input | 8 | Byte written |
| res_valid | output | 1 | Result present this cycle |
| res_unknown | output | 1 | Location cannot be determined |
| res_multi | output | 1 | Multi-bit group report |
| mod_mask | output | 8 | One-hot module or group mask |
| pin_num | output | PIN_W | Connector pin number |

## Verification
A wrong classification state shows in the second cycle after the request. It appears as a wrong unknown or multi flag, or a mask with the wrong number of bits set. A stale state shows as a result with no request two cycles before. A wrong table address or a wrong set choice shows only as a wrong bit position or pin value in that same cycle. For this reason the bench sweeps every syndrome, quadword, group and set, against shadow tables filled from arithmetic patterns.

// File: rtl/loc_pkg.sv
`timescale 1ns/1ps
package loc_pkg;
    localparam int QW_PER_LINE  = 4;
    localparam int QW_BITS      = 144;
    localparam int LINE_BITS    = QW_PER_LINE * QW_BITS;
    localparam int ENT_PER_BYTE = 4;
    localparam int MAP_BYTES    = LINE_BITS / ENT_PER_BYTE;
    localparam int GROUP_MODS   = 4;
    localparam int NUM_GROUPS   = 2;
    localparam int NUM_MODS     = GROUP_MODS * NUM_GROUPS;
    localparam int MOD_IDX_W    = $clog2(NUM_MODS);
    localparam int NUM_SETS     = 2;
    localparam int POS_W        = $clog2(LINE_BITS);
    localparam int MAP_IDX_W    = POS_W - 2;

    localparam int SYN_MULTI    = -1;
    localparam int SYN_MAX      = QW_BITS;
    localparam int LOW_LIM      = QW_BITS - 16;
    localparam int LOW_ADD      = 16;
    localparam int CHK_SUB      = QW_BITS - 7;
    localparam int TAG_LIM      = QW_BITS + 3;
    localparam int TAG_SUB      = QW_BITS + 3 - 4;
    localparam int OVER_SUB     = QW_BITS + 3;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_UNKNOWN = 2'd1,
        CLS_MULTI   = 2'd2,
        CLS_SINGLE  = 2'd3
    } cls_e;

    typedef struct packed {
        cls_e             cls;
        logic [POS_W-1:0] pos;
        logic             grp;
        logic             set;
    } stage_t;

    localparam stage_t STAGE_IDLE = '{cls: CLS_NONE, pos: '0, grp: 1'b0, set: 1'b0};
endpackage

// File: rtl/loc_classify.sv
`timescale 1ns/1ps
module loc_classify import loc_pkg::*; #(
    parameter int SYN_W = 9
) (
    input  logic                    req,
    input  logic signed [SYN_W-1:0] syndrome,
    input  logic [1:0]              qword,
    input  logic                    group,
    input  logic                    hit,
    input  logic                    sym,
    output stage_t                  nxt
);
    int s_i;
    int r_i;
    int p_i;

    always_comb begin
        s_i     = int'(syndrome);
        r_i     = 0;
        p_i     = 0;
        nxt     = STAGE_IDLE;
        nxt.grp = group;
        nxt.set = ~sym;
        if (req) begin
            if (!hit || s_i < SYN_MULTI || s_i > SYN_MAX) begin
                nxt.cls = CLS_UNKNOWN;
            end else if (s_i == SYN_MULTI) begin
                nxt.cls = CLS_MULTI;
            end else begin
                if (s_i < LOW_LIM)      r_i = s_i + LOW_ADD;
                else if (s_i < QW_BITS) r_i = s_i - CHK_SUB;
                else if (s_i < TAG_LIM) r_i = s_i - TAG_SUB;
                else                    r_i = s_i - OVER_SUB;
                p_i = (QW_PER_LINE - 1 - int'(qword)) * QW_BITS + r_i;
                if (p_i < 0) begin
                    nxt.cls = CLS_UNKNOWN;
                end else begin
                    nxt.cls = CLS_SINGLE;
                    nxt.pos = POS_W'(p_i);
                end
            end
        end
    end
endmodule

// File: rtl/loc_tables.sv
`timescale 1ns/1ps
module loc_tables import loc_pkg::*; #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wset,
    input  logic             wkind,
    input  logic [POS_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             rset,
    input  logic [POS_W-1:0] rpos,
    output logic             map_bit,
    output logic [PIN_W-1:0] pin
);
    logic [POS_W-1:0]     rev;
    logic [MAP_IDX_W-1:0] map_idx;
    logic [2:0]           bit_sel;
    logic [NUM_SETS-1:0]  set_bit;
    logic [PIN_W-1:0]     set_pin [NUM_SETS];

    assign rev     = POS_W'(LINE_BITS - 1) - rpos;
    assign map_idx = rev[POS_W-1:2];
    assign bit_sel = {~rev[1:0], 1'b0};

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        logic [7:0]       map_mem [MAP_BYTES];
        logic [PIN_W-1:0] pin_mem [LINE_BITS];

        always_ff @(posedge clk) begin
            if (we && wset == 1'(g)) begin
                if (!wkind && waddr < POS_W'(MAP_BYTES))
                    map_mem[waddr[MAP_IDX_W-1:0]] <= wdata;
                if (wkind && waddr < POS_W'(LINE_BITS))
                    pin_mem[waddr] <= PIN_W'(wdata);
            end
        end

        assign set_bit[g] = map_mem[map_idx][bit_sel];
        assign set_pin[g] = pin_mem[rpos];
    end

    assign map_bit = set_bit[rset];
    assign pin     = set_pin[rset];
endmodule

// File: rtl/loc_encode.sv
`timescale 1ns/1ps
module loc_encode import loc_pkg::*; (
    input  cls_e                cls,
    input  logic                group,
    input  logic                map_bit,
    output logic                valid,
    output logic                unknown,
    output logic                multi,
    output logic                single,
    output logic [NUM_MODS-1:0] mask
);
    localparam logic [NUM_MODS-1:0] GRP_MASK = NUM_MODS'((1 << GROUP_MODS) - 1);

    logic [MOD_IDX_W-1:0] sel;
    assign sel = MOD_IDX_W'(int'(group) * GROUP_MODS + int'(map_bit));

    always_comb begin
        valid   = 1'b0;
        unknown = 1'b0;
        multi   = 1'b0;
        single  = 1'b0;
        mask    = '0;
        unique case (cls)
            CLS_NONE: ;
            CLS_UNKNOWN: begin
                valid   = 1'b1;
                unknown = 1'b1;
            end
            CLS_MULTI: begin
                valid = 1'b1;
                multi = 1'b1;
                mask  = GRP_MASK << (int'(group) * GROUP_MODS);
            end
            CLS_SINGLE: begin
                valid  = 1'b1;
                single = 1'b1;
                mask   = NUM_MODS'(1) << sel;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/syn_dimm_locator.sv
`timescale 1ns/1ps
module syn_dimm_locator import loc_pkg::*; #(
    parameter int SYN_W = 9,
    parameter int PIN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic signed [SYN_W-1:0] syndrome,
    input  logic [1:0]              qword_sel,
    input  logic                    bank_group,
    input  logic                    bank_hit,
    input  logic                    layout_sym,
    input  logic                    tbl_we,
    input  logic                    tbl_set,
    input  logic                    tbl_kind,
    input  logic [POS_W-1:0]        tbl_addr,
    input  logic [7:0]              tbl_wdata,
    output logic                    res_valid,
    output logic                    res_unknown,
    output logic                    res_multi,
    output logic [NUM_MODS-1:0]     mod_mask,
    output logic [PIN_W-1:0]        pin_num
);
    stage_t              s1_d, s1_q;
    logic                t_bit;
    logic [PIN_W-1:0]    t_pin;
    logic                e_valid, e_unknown, e_multi, e_single;
    logic [NUM_MODS-1:0] e_mask;

    loc_classify #(.SYN_W(SYN_W)) u_cls (
        .req     (req),
        .syndrome(syndrome),
        .qword   (qword_sel),
        .group   (bank_group),
        .hit     (bank_hit),
        .sym     (layout_sym),
        .nxt     (s1_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= STAGE_IDLE;
        else        s1_q <= s1_d;
    end

    loc_tables #(.PIN_W(PIN_W)) u_tbl (
        .clk    (clk),
        .we     (tbl_we),
        .wset   (tbl_set),
        .wkind  (tbl_kind),
        .waddr  (tbl_addr),
        .wdata  (tbl_wdata),
        .rset   (s1_q.set),
        .rpos   (s1_q.pos),
        .map_bit(t_bit),
        .pin    (t_pin)
    );

    loc_encode u_enc (
        .cls    (s1_q.cls),
        .group  (s1_q.grp),
        .map_bit(t_bit),
        .valid  (e_valid),
        .unknown(e_unknown),
        .multi  (e_multi),
        .single (e_single),
        .mask   (e_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_unknown <= 1'b0;
            res_multi   <= 1'b0;
            mod_mask    <= '0;
            pin_num     <= '0;
        end else begin
            res_valid   <= e_valid;
            res_unknown <= e_unknown;
            res_multi   <= e_multi;
            mod_mask    <= e_mask;
            pin_num     <= e_single ? t_pin : '0;
        end
    end
endmodule

// File: rtl/loc_checker.sv
`timescale 1ns/1ps
module loc_checker import loc_pkg::*; #(
    parameter int SYN_W = 9,
    parameter int PIN_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req,
    input logic signed [SYN_W-1:0] syndrome,
    input logic                    bank_hit,
    input logic                    res_valid,
    input logic                    res_unknown,
    input logic                    res_multi,
    input logic [NUM_MODS-1:0]     mod_mask,
    input logic [PIN_W-1:0]        pin_num
);
    logic [1:0] since_q;
    logic       bad_syn;
    logic       no_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_q <= 2'd0;
        else if (since_q != 2'd2) since_q <= since_q + 2'd1;
    end

    assign bad_syn = req && (int'(syndrome) < SYN_MULTI || int'(syndrome) > SYN_MAX);
    assign no_bank = req && !bank_hit;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (mod_mask == '0 && pin_num == '0 && !res_unknown && !res_multi)); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd2) |-> (res_valid == $past(req, 2))); // R2
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd2 && $past(bad_syn, 2)) |-> res_unknown); // R3
    AST_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd2 && $past(no_bank, 2)) |-> res_unknown); // R3
    AST_UNKNOWN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_unknown) |-> (mod_mask == '0 && pin_num == '0 && !res_multi)); // R3
    AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_unknown && !res_multi) |-> ($countones(mod_mask) == 1)); // R6
    AST_MULTI_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_multi) |-> (mod_mask == 8'h0F || mod_mask == 8'hF0)); // R9
endmodule

bind syn_dimm_locator loc_checker #(.SYN_W(SYN_W), .PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .syndrome   (syndrome),
    .bank_hit   (bank_hit),
    .res_valid  (res_valid),
    .res_unknown(res_unknown),
    .res_multi  (res_multi),
    .mod_mask   (mod_mask),
    .pin_num    (pin_num)
);

// File: tb/tb_syn_dimm_locator.sv
`timescale 1ns/1ps
module tb_syn_dimm_locator;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic signed [8:0] syndrome = '0;
    logic [1:0]        qword_sel = '0;
    logic              bank_group = 1'b0;
    logic              bank_hit = 1'b0;
    logic              layout_sym = 1'b0;
    logic              tbl_we = 1'b0;
    logic              tbl_set = 1'b0;
    logic              tbl_kind = 1'b0;
    logic [9:0]        tbl_addr = '0;
    logic [7:0]        tbl_wdata = '0;
    logic              res_valid, res_unknown, res_multi;
    logic [7:0]        mod_mask, pin_num;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] bmap [2][144];
    logic [7:0] bpin [2][576];

    always #5 clk = ~clk;

    syn_dimm_locator dut (
        .clk(clk), .rst_n(rst_n), .req(req), .syndrome(syndrome),
        .qword_sel(qword_sel), .bank_group(bank_group), .bank_hit(bank_hit),
        .layout_sym(layout_sym), .tbl_we(tbl_we), .tbl_set(tbl_set),
        .tbl_kind(tbl_kind), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .res_valid(res_valid), .res_unknown(res_unknown), .res_multi(res_multi),
        .mod_mask(mod_mask), .pin_num(pin_num)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {13'd0, res_valid, res_unknown, res_multi, mod_mask, pin_num};
    endfunction

    task automatic wr(input int set, input int kind, input int addr, input logic [7:0] d);
        tbl_we = 1'b1; tbl_set = 1'(set); tbl_kind = 1'(kind);
        tbl_addr = 10'(addr); tbl_wdata = d;
        if (kind == 0) bmap[set][addr] = d; else bpin[set][addr] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    function automatic logic [31:0] model(input int sym, input int grp, input int qw,
                                          input int s, input int hit, output string tag);
        int set, r, pos, rev, b;
        logic [7:0] mk, pn;
        logic u, m;
        set = sym ? 0 : 1;
        mk = 0; pn = 0; u = 0; m = 0;
        if (hit == 0 || s < -1 || s > 144) begin
            u = 1; tag = "R3";
        end else if (s == -1) begin
            m = 1; mk = grp ? 8'hF0 : 8'h0F; tag = "R9";
        end else begin
            if (s < 128)      r = s + 16;
            else if (s < 144) r = s - 137;
            else              r = s - 143;
            pos = (3 - qw) * 144 + r;
            if (pos < 0) begin
                u = 1; tag = "R5";
            end else begin
                rev = 575 - pos;
                b = int'(bmap[set][rev / 4]);
                mk = 8'(1) << (grp * 4 + ((b >> (2 * (3 - rev % 4))) & 1));
                pn = bpin[set][pos];
                tag = "R4 R5 R6 R7 R8";
            end
        end
        return {13'd0, 1'b1, u, m, mk, pn};
    endfunction

    task automatic drive(input int sym, input int grp, input int qw, input int s, input int hit);
        req = 1'b1; layout_sym = 1'(sym); bank_group = 1'(grp);
        qword_sel = 2'(qw); syndrome = 9'(s); bank_hit = 1'(hit);
    endtask

    task automatic run(input int sym, input int grp, input int qw, input int s, input int hit);
        string tag;
        logic [31:0] exp;
        exp = model(sym, grp, qw, s, hit, tag);
        drive(sym, grp, qw, s, hit);
        @(negedge clk);
        req = 1'b0;
        check("R2", "no result one cycle after request", outs(), 32'd0);
        @(negedge clk);
        check(tag, $sformatf("sym=%0d grp=%0d qw=%0d syn=%0d hit=%0d", sym, grp, qw, s, hit),
              outs(), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string t0, t1;
        logic [31:0] e0, e1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "outputs after reset", outs(), 32'd0);
        @(negedge clk);
        check("R1", "outputs idle", outs(), 32'd0);

        // R10: fill both sets of both tables
        for (int st = 0; st < 2; st++) begin
            for (int i = 0; i < 144; i++) wr(st, 0, i, 8'((i * 37 + st * 101 + 5) & 255));
            for (int j = 0; j < 576; j++) wr(st, 1, j, 8'((j * 11 + st * 59 + 3) & 255));
        end
        check("R1", "outputs idle after load", outs(), 32'd0);

        // R3 R4 R5 R6 R7 R8 R9: sweep with bank claimed
        for (int sym = 0; sym < 2; sym++)
            for (int grp = 0; grp < 2; grp++)
                for (int qw = 0; qw < 4; qw++) begin
                    for (int s = -3; s <= 150; s++) run(sym, grp, qw, s, 1);
                    run(sym, grp, qw, -100, 1);
                    run(sym, grp, qw, 255, 1);
                    run(sym, grp, qw, -256, 1);
                end

        // R3: no bank claimed
        for (int sym = 0; sym < 2; sym++)
            for (int grp = 0; grp < 2; grp++)
                for (int qw = 0; qw < 4; qw++) begin
                    run(sym, grp, qw, -1, 0);
                    run(sym, grp, qw, 0, 0);
                    run(sym, grp, qw, 77, 0);
                    run(sym, grp, qw, 144, 0);
                end

        // R10: rewrite entries of set 1 used by syndrome 0, qword 0 (pos 448, map byte 31)
        wr(1, 0, 31, bmap[1][31] ^ 8'h01);
        wr(1, 1, 448, 8'hA5);
        run(0, 0, 0, 0, 1);
        run(0, 1, 0, 0, 1);
        run(1, 0, 0, 0, 1);
        wr(1, 0, 31, bmap[1][31] ^ 8'h01);
        run(0, 1, 0, 0, 1);

        // R2: back-to-back requests
        e0 = model(1, 0, 2, 5, 1, t0);
        e1 = model(0, 1, 1, -1, 1, t1);
        drive(1, 0, 2, 5, 1);
        @(negedge clk);
        drive(0, 1, 1, -1, 1);
        @(negedge clk);
        req = 1'b0;
        check("R2", "first of back-to-back pair", outs(), e0);
        @(negedge clk);
        check("R2", "second of back-to-back pair", outs(), e1);
        @(negedge clk);
        check("R1", "idle after pair", outs(), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule